// File: doc/BRIEF.md
# Fractional Divider Clock Source Selector

This block produces a clock-enable pulse train for one peripheral. Up to sixteen source inputs each carry a single-cycle tick stream, all in the system clock domain. A source field in the control register chooses one of them. The chosen stream is then divided by a fixed-point divisor that has an integer part and a fractional part. Over a long run the output pulse rate is the source tick rate times 2^FRAC_BITS divided by the divisor value.

Source numbers 0 to 3 have fixed roles:

- Source 0 is ground and never ticks.
- Source 1 is the main oscillator.
- Sources 2 and 3 are test clocks.

Higher source numbers carry channel outputs. A parameter mask can tie any of them to ground.

Software programs two registers through a simple write port. The control register holds the enable, the source number and a busy flag. The divide register holds the divisor. Any write to either register restarts the division from a clean state.

Top module: `fdivclk_sel`

## Requirements
- R1: After reset, the control readback, the divide readback and `clkEnOut` are all zero.
- R2: While the enable bit (control bit 4) is clear, `clkEnOut` stays low whatever the source ticks do.
- R3: The busy flag (control bit 7) always reads equal to the enable bit. Data written to bit 7 is ignored.
- R4: The source number (control bits 3:0) selects which `srcTick` bit drives the divider. Ticks on every other source have no effect.
- R5: Source 0 is ground: with source 0 selected, no pulse is ever produced.
- R6: A source whose bit is set in `GND_MASK` (default: source 15) behaves as ground.
- R7: The divisor is taken from the divide register as follows. The integer part sits at bits 12 and up (INT_BITS wide). The fractional part sits in the FRAC_BITS bits just below bit 12. All other written bits are ignored and read back as zero.
- R8: A divisor value of zero stops the output.
- R9: Start from a write to either register and let n selected ticks arrive. If the divisor d is at least 2^FRAC_BITS, exactly floor(n·2^FRAC_BITS/d) pulses have then been produced.
- R10: When d is below 2^FRAC_BITS, every selected tick produces one pulse, so the output saturates at the source rate.
- R11: A write to either register discards any partial accumulation, and the tick that arrives in the write cycle is dropped.
- R12: Each pulse is one cycle wide and appears in the cycle after the tick that caused it.
- R13: With INT_BITS and FRAC_BITS both zero, the selected enabled source passes straight through with the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = control, 1 = divide |
| wrData | input | 32 | Write data |
| srcTick | input | NUM_SRC | Per-source tick inputs |
| ctrlRd | output | 32 | Control register readback |
| divRd | output | 32 | Divide register readback |
| clkEnOut | output | 1 | Output clock-enable pulse |

## Verification
Every divisor from 1 to 255 is tried with the selected source ticking on every cycle. The resulting pulse counts separate the saturating range below 2^FRAC_BITS from the exact floor counts above it. Sparse tick patterns (one tick every two or three cycles) on other sources show that the output rate follows selected ticks and not clock cycles. During those runs all unselected sources tick constantly, which exposes any leakage from them.

Short runs cover four more cases:

- A rewrite of the same divisor, to separate accumulator clearing from plain carry-over.
- A single isolated tick, to fix the output latency.
- The ground and masked sources.
- A pass-through instance with a zero divisor.

// File: rtl/fdivclk_pkg.sv
package fdivclk_pkg;
  localparam int EnBit     = 4;
  localparam int BusyBit   = 7;
  localparam int DivIntLsb = 12;

  typedef struct packed {
    logic tick;   // selected source ticked, enabled, divisor usable
    logic clear;  // restart accumulation
  } strobe_t;
endpackage

// File: rtl/fdivclk_ctrl.sv
module fdivclk_ctrl
  import fdivclk_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int INT_BITS = 4,
  parameter int FRAC_BITS = 4,
  parameter logic [NUM_SRC-1:0] GND_MASK = 16'h8000,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam bit PASS = (INT_BITS + FRAC_BITS) == 0,
  localparam int DW = PASS ? 1 : INT_BITS + FRAC_BITS,
  localparam int LSB = DivIntLsb - FRAC_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [31:0]        wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic [31:0]        ctrlRd,
  output logic [31:0]        divRd,
  output logic [DW-1:0]      divVal,
  output strobe_t            strobe
);
  logic [SRC_W-1:0] srcSel;
  logic             enReg;
  logic             busyReg;
  logic [DW-1:0]    divField;
  logic [NUM_SRC-1:0] liveTick;
  logic             selTick;
  logic             divUsable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel   <= '0;
      enReg    <= 1'b0;
      busyReg  <= 1'b0;
      divField <= '0;
    end else if (wrEn) begin
      if (!wrSel) begin
        srcSel  <= wrData[SRC_W-1:0];
        enReg   <= wrData[EnBit];
        busyReg <= wrData[EnBit];
      end else begin
        divField <= wrData[LSB +: DW];
      end
    end
  end

  // source 0 and masked sources are ground
  always_comb begin
    liveTick    = srcTick & ~GND_MASK;
    liveTick[0] = 1'b0;
  end

  assign selTick   = (int'(srcSel) < NUM_SRC) ? liveTick[srcSel] : 1'b0;
  assign divUsable = PASS || (divField != '0);
  assign divVal    = divField;

  assign strobe.tick  = enReg && selTick && divUsable && !wrEn;
  assign strobe.clear = wrEn || !enReg;

  always_comb begin
    ctrlRd                = '0;
    ctrlRd[SRC_W-1:0]     = srcSel;
    ctrlRd[EnBit]         = enReg;
    ctrlRd[BusyBit]       = busyReg;
    divRd                 = '0;
    if (!PASS) divRd[LSB +: DW] = divField;
  end

  assert_busy_tracks_R3: assert property (@(posedge clk) disable iff (!rstN)
    busyReg == enReg);
  assert_ground_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == '0) |-> !strobe.tick);
endmodule

// File: rtl/fdivclk_dp.sv
module fdivclk_dp
  import fdivclk_pkg::*;
#(
  parameter int INT_BITS = 4,
  parameter int FRAC_BITS = 4,
  localparam bit PASS = (INT_BITS + FRAC_BITS) == 0,
  localparam int DW = PASS ? 1 : INT_BITS + FRAC_BITS,
  localparam int AW = DW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [DW-1:0] divVal,
  output logic          pulse
);
  generate
    if (PASS) begin : gPass
      always_ff @(posedge clk) begin
        if (!rstN) pulse <= 1'b0;
        else       pulse <= strobe.tick && !strobe.clear;
      end
    end else begin : gFrac
      localparam logic [AW-1:0] STEP = AW'(1) << FRAC_BITS;
      logic [AW-1:0] acc;
      logic [AW-1:0] sum;
      logic [AW-1:0] divExt;

      assign divExt = {1'b0, divVal};
      assign sum    = acc + STEP;

      always_ff @(posedge clk) begin
        if (!rstN || strobe.clear) begin
          acc   <= '0;
          pulse <= 1'b0;
        end else if (strobe.tick) begin
          if (divExt <= STEP) begin
            acc   <= '0;
            pulse <= 1'b1;
          end else if (sum >= divExt) begin
            acc   <= sum - divExt;
            pulse <= 1'b1;
          end else begin
            acc   <= sum;
            pulse <= 1'b0;
          end
        end else begin
          pulse <= 1'b0;
        end
      end

      assert_acc_below_div_R9: assert property (@(posedge clk) disable iff (!rstN)
        (divVal != '0) |-> (acc < divExt));
      assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
        strobe.clear |=> (acc == '0) && !pulse);
    end
  endgenerate
endmodule

// File: rtl/fdivclk_sel.sv
module fdivclk_sel
  import fdivclk_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int INT_BITS = 4,
  parameter int FRAC_BITS = 4,
  parameter logic [NUM_SRC-1:0] GND_MASK = 16'h8000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [31:0]        wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic [31:0]        ctrlRd,
  output logic [31:0]        divRd,
  output logic               clkEnOut
);
  localparam bit PASS = (INT_BITS + FRAC_BITS) == 0;
  localparam int DW = PASS ? 1 : INT_BITS + FRAC_BITS;

  strobe_t       strobe;
  logic [DW-1:0] divVal;

  fdivclk_ctrl #(
    .NUM_SRC(NUM_SRC), .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .GND_MASK(GND_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .srcTick(srcTick), .ctrlRd(ctrlRd), .divRd(divRd), .divVal(divVal),
    .strobe(strobe)
  );

  fdivclk_dp #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divVal(divVal), .pulse(clkEnOut)
  );

  assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRd[EnBit] |=> !clkEnOut);
  assert_zero_div_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!PASS && divRd == 32'd0) |=> !clkEnOut);
  assert_pulse_needs_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(|srcTick) |=> !clkEnOut);
endmodule

// File: tb/sim_fdivclk_sel.sv
`timescale 1ns/1ps
module sim_fdivclk_sel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [15:0] srcTick = '0;
  logic [31:0] ctrlRd, divRd, ctrlRd1, divRd1;
  logic        clkEnOut, clkEnOut1;

  int compared = 0;
  int mismatched = 0;
  int cnt0 = 0;
  int cnt1 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdivclk_sel u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .srcTick(srcTick), .ctrlRd(ctrlRd), .divRd(divRd), .clkEnOut(clkEnOut)
  );

  fdivclk_sel #(.INT_BITS(0), .FRAC_BITS(0)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .srcTick(srcTick), .ctrlRd(ctrlRd1), .divRd(divRd1), .clkEnOut(clkEnOut1)
  );

  always @(negedge clk) begin
    if (clkEnOut)  cnt0 <= cnt0 + 1;
    if (clkEnOut1) cnt1 <= cnt1 + 1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // n ticks on source src, gap idle cycles after each; all other sources tick constantly
  task automatic run(input int src, input int n, input int gap);
    @(negedge clk);
    cnt0 = 0; cnt1 = 0;
    for (int i = 0; i < n; i++) begin
      srcTick = 16'hFFFF;
      if (gap > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          srcTick = 16'hFFFF & ~(16'h1 << src);
        end
      end
      @(negedge clk);
    end
    srcTick = '0;
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic int expect_cnt(input int n, input int d);
    if (d == 0) return 0;
    if (d <= 16) return n;
    return (n * 16) / d;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 ctrlRd", ctrlRd, 0);
    check("R1 divRd", divRd, 0);
    check("R1 clkEnOut", clkEnOut, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R3: busy follows enable, written bit 7 ignored
    wr(1'b0, 32'h0000_0081);
    #1 check("R3 busy low with enable low", ctrlRd, 32'h01);
    wr(1'b0, 32'h0000_0011);
    #1 check("R3 busy high with enable high", ctrlRd, 32'h91);

    // R7: only divisor field is kept
    wr(1'b1, 32'hFFFF_FFFF);
    #1 check("R7 divisor field readback", divRd, 32'h0000_FF00);

    // R9 / R10: full divisor sweep, every-cycle ticks on source 1
    for (int d = 1; d < 256; d++) begin
      wr(1'b1, d << 8);
      run(1, 40, 0);
      check($sformatf("R9 R10 d=%0d", d), cnt0, expect_cnt(40, d));
    end

    // R4: sparse ticks on source 2 and 3, others noisy
    wr(1'b0, 32'h0000_0012);
    for (int d = 17; d < 65; d++) begin
      wr(1'b1, d << 8);
      run(2, 30, 2);
      check($sformatf("R4 src2 d=%0d", d), cnt0, expect_cnt(30, d));
    end
    wr(1'b0, 32'h0000_0013);
    for (int d = 100; d < 111; d++) begin
      wr(1'b1, d << 8);
      run(3, 25, 1);
      check($sformatf("R4 src3 d=%0d", d), cnt0, expect_cnt(25, d));
    end

    // R8 / R13: zero divisor field with surrounding bits set; pass-through ignores it
    wr(1'b0, 32'h0000_0011);
    wr(1'b1, 32'hFFFF_00FF);
    run(1, 20, 1);
    check("R8 zero divisor", cnt0, 0);
    check("R13 pass-through", cnt1, 20);

    // R2: enable off
    wr(1'b1, 32'h0000_1000);
    wr(1'b0, 32'h0000_0001);
    run(1, 20, 0);
    check("R2 disabled u0", cnt0, 0);
    check("R2 disabled u1", cnt1, 0);

    // R5 / R6: ground sources
    wr(1'b0, 32'h0000_0010);
    run(0, 20, 1);
    check("R5 source 0 u0", cnt0, 0);
    check("R5 source 0 u1", cnt1, 0);
    wr(1'b0, 32'h0000_001F);
    run(15, 20, 1);
    check("R6 masked source u0", cnt0, 0);
    check("R6 masked source u1", cnt1, 0);

    // R11: rewrite clears the partial accumulation
    wr(1'b0, 32'h0000_0011);
    wr(1'b1, 32'h0000_1800);
    run(1, 1, 0);
    check("R11 first half tick", cnt0, 0);
    wr(1'b1, 32'h0000_1800);
    run(1, 1, 0);
    check("R11 after rewrite", cnt0, 0);
    run(1, 1, 0);
    check("R11 carry without write", cnt0, 1);

    // R12: latency and width
    wr(1'b1, 32'h0000_1000);
    @(negedge clk);
    srcTick = 16'h0002;
    #1 check("R12 no pulse in tick cycle", clkEnOut, 0);
    @(negedge clk);
    srcTick = '0;
    #1 check("R12 pulse next cycle", clkEnOut, 1);
    check("R13 pass-through latency", clkEnOut1, 1);
    @(negedge clk);
    #1 check("R12 single-cycle pulse", clkEnOut, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule